// File: doc/BRIEF.md
# Per-Operand Element Offset Remapper

This block shifts the element indices of a vector instruction's operands by a programmable amount. A setup operation writes three values into it: an offset, a five-bit operand-select mask and a persistence mode. From then on, the block adds the offset to the base element index of every operand whose mask bit is set. Operands whose mask bit is clear keep their base index. The offset counts in elements, not in whole registers, so it can reach sub-register elements when element widths are overridden.

When the persistence mode is zero, the configuration is one-shot. It stays armed until the next vector instruction signals completion, and then it clears itself. When the mode is nonzero, the configuration stays active until a later setup replaces it. A setup with an all-zero mask disables remapping. The index path is purely combinational. Only the configuration is held in registers. The block never touches the vector length.

Top module: `elem_ofs_remap`

## Requirements
- R1: While reset is asserted, and after it is released until a setup is applied, `remap_active` is 0, every adjusted index equals its base index, and every carry flag is 0.
- R2: A setup accepted at a rising clock edge takes effect immediately after that edge. Each selected operand's adjusted index then equals its base index plus `cfg_offset`.
- R3: Mask bits map to operands as follows: bit 0 is RA, bit 1 is RB, bit 2 is RC, bit 3 is RT and bit 4 is RS. Operand k occupies bits [k*IDX_W +: IDX_W] of `base_idx` and `adj_idx`, and bit k of `idx_carry`.
- R4: An operand whose mask bit is clear passes its base index through unchanged, and its carry flag is 0.
- R5: With persistence mode 0, the configuration stays active across idle cycles. It clears at the first edge where `insn_done` is high, after which every index passes through unchanged and `remap_active` is 0.
- R6: With a nonzero persistence mode, `insn_done` has no effect. The offset stays applied after it.
- R7: When a setup and `insn_done` arrive in the same cycle, the new setup is kept, even if it is one-shot.
- R8: A new setup fully replaces the previous one. A setup with mask 0 leaves `remap_active` at 0 and all indices unchanged.
- R9: When base plus offset reaches 2^IDX_W or more, the adjusted index wraps modulo 2^IDX_W and the operand's carry flag is 1. Otherwise the carry flag is 0.
- R10: `remap_active` is 1 exactly when the stored mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Setup operation strobe |
| cfg_offset | input | IDX_W | Element offset to apply |
| cfg_mask | input | 5 | Operand-select mask (bit0 RA … bit4 RS) |
| cfg_pmode | input | PMODE_W | Persistence mode; 0 means one-shot |
| insn_done | input | 1 | A vector instruction completed this cycle |
| base_idx | input | 5*IDX_W | Base element index per operand |
| adj_idx | output | 5*IDX_W | Adjusted element index per operand |
| idx_carry | output | 5 | Per-operand overflow flag |
| remap_active | output | 1 | A configuration is armed |

## Verification
The bench builds the block with IDX_W=7, which gives a 128-element index space, and with PMODE_W=2. At that width, an offset of 1 on base 127 wraps to 0 and sets the carry flag, while base 126 reaches 127 with no carry, so the exact overflow boundary can be checked directly. A two-bit mode field also lets the bench use a persistence value other than 1, which confirms that any nonzero mode makes the configuration persistent.

// File: rtl/elem_ofs_pkg.sv
// Shared definitions for the element offset remapper.
// Assumes a fixed set of five remappable operand slots.
package elem_ofs_pkg;
    localparam int NUM_OPS = 5;

    // Operand slot order: the position matches the mask bit that selects it.
    typedef enum int unsigned {
        OP_RA = 0,
        OP_RB = 1,
        OP_RC = 2,
        OP_RT = 3,
        OP_RS = 4
    } operand_e;
endpackage

// File: rtl/elem_ofs_cfg.sv
// Configuration register for the remapper. It holds the offset, the operand
// mask and the persistence flag. A setup always wins over a one-shot clear.
// Assumes insn_done pulses once per completed vector instruction.
module elem_ofs_cfg #(
    parameter int IDX_W   = 7,
    parameter int PMODE_W = 2,
    parameter int NOPS    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_valid,
    input  logic [IDX_W-1:0]   cfg_offset,
    input  logic [NOPS-1:0]    cfg_mask,
    input  logic [PMODE_W-1:0] cfg_pmode,
    input  logic               insn_done,
    output logic [IDX_W-1:0]   ofs_q,
    output logic [NOPS-1:0]    mask_q,
    output logic               persist_q
);
    // Load a setup, consume a one-shot config, or hold the current state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q     <= '0;
            mask_q    <= '0;
            persist_q <= 1'b0;
        end else if (cfg_valid) begin
            ofs_q     <= cfg_offset;
            mask_q    <= cfg_mask;
            persist_q <= |cfg_pmode;
        end else if (insn_done && !persist_q) begin
            mask_q    <= '0;
        end
    end
endmodule

// File: rtl/elem_ofs_add.sv
// Adjusts one operand's element index. When enabled, it adds the offset and
// reports the carry out of the index range. When disabled, it passes the
// base index through unchanged. Assumes the offset is as wide as the index.
module elem_ofs_add #(
    parameter int IDX_W = 7
) (
    input  logic [IDX_W-1:0] base,
    input  logic [IDX_W-1:0] ofs,
    input  logic             en,
    output logic [IDX_W-1:0] adj,
    output logic             carry
);
    logic [IDX_W-1:0] ofs_eff;

    // Gate the offset with the operand enable.
    always_comb ofs_eff = en ? ofs : '0;

    // Widen by one bit so the carry comes out of the sum.
    always_comb {carry, adj} = {1'b0, base} + {1'b0, ofs_eff};
endmodule

// File: rtl/elem_ofs_remap.sv
// Top level of the per-operand element offset remapper. A registered
// configuration drives five combinational index adders.
// Assumes the setup opcode is decoded upstream, and that no register file
// access takes place here.
module elem_ofs_remap #(
    parameter int IDX_W   = 7,
    parameter int PMODE_W = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_valid,
    input  logic [IDX_W-1:0]                      cfg_offset,
    input  logic [elem_ofs_pkg::NUM_OPS-1:0]      cfg_mask,
    input  logic [PMODE_W-1:0]                    cfg_pmode,
    input  logic                                  insn_done,
    input  logic [elem_ofs_pkg::NUM_OPS*IDX_W-1:0] base_idx,
    output logic [elem_ofs_pkg::NUM_OPS*IDX_W-1:0] adj_idx,
    output logic [elem_ofs_pkg::NUM_OPS-1:0]      idx_carry,
    output logic                                  remap_active
);
    localparam int NOPS = elem_ofs_pkg::NUM_OPS;

    logic [IDX_W-1:0] ofs_q;
    logic [NOPS-1:0]  mask_q;
    logic             persist_q;

    elem_ofs_cfg #(.IDX_W(IDX_W), .PMODE_W(PMODE_W), .NOPS(NOPS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_offset(cfg_offset),
        .cfg_mask  (cfg_mask),
        .cfg_pmode (cfg_pmode),
        .insn_done (insn_done),
        .ofs_q     (ofs_q),
        .mask_q    (mask_q),
        .persist_q (persist_q)
    );

    // One adder per operand slot, enabled by that slot's mask bit.
    for (genvar k = 0; k < NOPS; k++) begin : g_op
        elem_ofs_add #(.IDX_W(IDX_W)) u_add (
            .base (base_idx[k*IDX_W +: IDX_W]),
            .ofs  (ofs_q),
            .en   (mask_q[k]),
            .adj  (adj_idx[k*IDX_W +: IDX_W]),
            .carry(idx_carry[k])
        );
    end

    // The remap is armed whenever any operand is selected.
    always_comb remap_active = |mask_q;
endmodule

// File: rtl/elem_ofs_remap_chk.sv
// Assertion checker for elem_ofs_remap, attached with bind. It watches the
// ports and the stored configuration over time.
module elem_ofs_remap_chk #(
    parameter int IDX_W = 7,
    parameter int NOPS  = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_valid,
    input logic [NOPS-1:0]       cfg_mask,
    input logic                  insn_done,
    input logic [NOPS*IDX_W-1:0] base_idx,
    input logic [NOPS*IDX_W-1:0] adj_idx,
    input logic [NOPS-1:0]       idx_carry,
    input logic                  remap_active,
    input logic [NOPS-1:0]       mask_q,
    input logic                  persist_q
);
    // R1
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !remap_active |-> (adj_idx == base_idx) && (idx_carry == '0));

    // R5
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done && !cfg_valid && !persist_q |=> !remap_active);

    // R6
    persist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done && !cfg_valid && persist_q && remap_active |=> remap_active);

    // R7
    setup_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && (cfg_mask != '0) |=> remap_active);

    for (genvar k = 0; k < NOPS; k++) begin : g_op
        // R4
        unsel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mask_q[k] |-> (adj_idx[k*IDX_W +: IDX_W] == base_idx[k*IDX_W +: IDX_W])
                           && !idx_carry[k]);
        // R9
        wrap_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
            idx_carry[k] |-> adj_idx[k*IDX_W +: IDX_W] < base_idx[k*IDX_W +: IDX_W]);
    end
endmodule

bind elem_ofs_remap elem_ofs_remap_chk #(.IDX_W(IDX_W), .NOPS(elem_ofs_pkg::NUM_OPS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_valid   (cfg_valid),
    .cfg_mask    (cfg_mask),
    .insn_done   (insn_done),
    .base_idx    (base_idx),
    .adj_idx     (adj_idx),
    .idx_carry   (idx_carry),
    .remap_active(remap_active),
    .mask_q      (mask_q),
    .persist_q   (persist_q)
);

// File: tb/elem_ofs_remap_test.sv
module elem_ofs_remap_test;
    localparam int IDX_W = 7;
    localparam int PMW   = 2;
    localparam int NOPS  = 5;
    localparam int RANGE = 1 << IDX_W;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  cfg_valid = 1'b0;
    logic [IDX_W-1:0]      cfg_offset = '0;
    logic [NOPS-1:0]       cfg_mask = '0;
    logic [PMW-1:0]        cfg_pmode = '0;
    logic                  insn_done = 1'b0;
    logic [NOPS*IDX_W-1:0] base_idx = '0;
    logic [NOPS*IDX_W-1:0] adj_idx;
    logic [NOPS-1:0]       idx_carry;
    logic                  remap_active;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    elem_ofs_remap #(.IDX_W(IDX_W), .PMODE_W(PMW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_offset(cfg_offset),
        .cfg_mask(cfg_mask), .cfg_pmode(cfg_pmode), .insn_done(insn_done),
        .base_idx(base_idx), .adj_idx(adj_idx), .idx_carry(idx_carry),
        .remap_active(remap_active)
    );

    always #10 clk = ~clk;

    // Each vector packs {mask, offset, base seed}.
    localparam logic [NOPS+2*IDX_W-1:0] VEC [0:5] = '{
        {5'b00011, 7'd5,   7'd10},
        {5'b11111, 7'd1,   7'd0},
        {5'b10100, 7'd33,  7'd40},
        {5'b01000, 7'd127, 7'd2},
        {5'b00001, 7'd20,  7'd120},
        {5'b11010, 7'd64,  7'd70}
    };

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_op(string req, int op, int exp_idx, int exp_c);
        chk(req, int'(adj_idx[op*IDX_W +: IDX_W]), exp_idx);
        chk(req, int'(idx_carry[op]), exp_c);
    endtask

    task automatic set_base(int op, int val);
        base_idx[op*IDX_W +: IDX_W] = IDX_W'(val);
    endtask

    task automatic setup(logic [NOPS-1:0] m, int ofs, logic [PMW-1:0] pm, logic done);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_mask = m; cfg_offset = IDX_W'(ofs); cfg_pmode = pm;
        insn_done = done;
        @(negedge clk);
        cfg_valid = 1'b0; insn_done = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: during reset and before any setup, indices pass through.
        for (int k = 0; k < NOPS; k++) set_base(k, 11 * k + 3);
        repeat (3) @(negedge clk);
        #1;
        chk("R1 active in reset", int'(remap_active), 0);
        for (int k = 0; k < NOPS; k++) chk_op("R1 reset pass", k, 11 * k + 3, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 active after reset", int'(remap_active), 0);
        chk_op("R1 after reset", 2, 25, 0);

        // R2 R3 R4 R9: table walk with persistent configs.
        for (int v = 0; v < 6; v++) begin
            logic [NOPS-1:0] m;
            int ofs, seed;
            m    = VEC[v][NOPS+2*IDX_W-1 -: NOPS];
            ofs  = int'(VEC[v][2*IDX_W-1 -: IDX_W]);
            seed = int'(VEC[v][IDX_W-1:0]);
            setup(m, ofs, 2'b01, 1'b0);
            for (int k = 0; k < NOPS; k++) set_base(k, (seed + 23 * k) % RANGE);
            #1;
            for (int k = 0; k < NOPS; k++) begin
                int b, s;
                b = (seed + 23 * k) % RANGE;
                s = b + ofs;
                if (m[k]) chk_op("R2/R3/R9 table selected", k, s % RANGE, (s >= RANGE) ? 1 : 0);
                else      chk_op("R4 table unselected", k, b, 0);
            end
            chk("R10 active", int'(remap_active), 1);
        end

        // R5: a one-shot config survives idle cycles, then clears on insn_done.
        for (int k = 0; k < NOPS; k++) set_base(k, 10 * k);
        setup(5'b01000, 3, 2'b00, 1'b0);
        repeat (3) @(negedge clk);
        #1;
        chk_op("R5 one-shot armed", 3, 33, 0);
        chk_op("R5 one-shot RA untouched", 0, 0, 0);
        pulse_done();
        #1;
        chk("R5 active after done", int'(remap_active), 0);
        chk_op("R5 cleared RT", 3, 30, 0);

        // R6: a persistent config with mode 2 ignores insn_done.
        setup(5'b10000, 4, 2'b10, 1'b0);
        pulse_done();
        pulse_done();
        #1;
        chk_op("R6 persistent RS", 4, 44, 0);
        chk("R6 active", int'(remap_active), 1);

        // R7: a setup and insn_done in the same cycle keep the new setup.
        setup(5'b00100, 6, 2'b00, 1'b1);
        #1;
        chk_op("R7 setup kept", 2, 26, 0);
        chk_op("R7 old RS off", 4, 40, 0);
        chk("R7 active", int'(remap_active), 1);
        pulse_done();
        #1;
        chk_op("R5 cleared after R7", 2, 20, 0);

        // R8: a new setup replaces the old one, and mask 0 disables remapping.
        setup(5'b00001, 1, 2'b01, 1'b0);
        setup(5'b00010, 2, 2'b01, 1'b0);
        #1;
        chk_op("R8 RA replaced", 0, 0, 0);
        chk_op("R8 RB new", 1, 12, 0);
        setup(5'b00000, 9, 2'b01, 1'b0);
        #1;
        chk("R8 mask0 active", int'(remap_active), 0);
        for (int k = 0; k < NOPS; k++) chk_op("R8 mask0 pass", k, 10 * k, 0);

        // R9: the exact wrap boundary, and a zero offset.
        setup(5'b11111, 1, 2'b01, 1'b0);
        set_base(0, 127); set_base(1, 126); set_base(2, 0);
        #1;
        chk_op("R9 wrap", 0, 0, 1);
        chk_op("R9 top no carry", 1, 127, 0);
        chk_op("R9 low", 2, 1, 0);
        setup(5'b11111, 0, 2'b01, 1'b0);
        #1;
        chk_op("R9 zero offset", 0, 127, 0);
        chk("R10 active zero ofs", int'(remap_active), 1);

        // R1: a reset clears an active configuration.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 reset clears", int'(remap_active), 0);
        chk_op("R1 reset pass RA", 0, 127, 0);

        finish_run();
    end
endmodule